// File: doc/BRIEF.md
# Interrupt Signalling Mode Controller

This block sits between a device's interrupt sources and its outbound request path. Each source presents a level. Software picks one of three ways to signal those sources. In the legacy form, the sources share one level-style interrupt line and the block sends virtual-wire messages: an assert message when the combined level rises and a deassert message when it falls. In the single-address form, each rising source edge produces a memory write to one shared address, and the data value carries the vector number. In the table form, each vector has its own programmable address, data word and mask bit.

Each descriptor leaves the block on a registered output that is valid for one cycle. The descriptor kinds are idle, assert message, deassert message and memory write. The block makes at most one descriptor per cycle. Firings that overlap wait in per-vector pending bits and go out in fixed priority order. When software grants fewer vectors than the sources need, the single-address form folds the vector numbers onto the grant. When a message mode turns on while the legacy line is still up, a deassert message goes out before anything else.

Top module: `irq_mode_ctrl`

## Requirements
- R1: In legacy mode (`msi_en`=0 and `tbl_en`=0), a rise of the OR of all sources while the line is down gives one descriptor with `out_kind`=2'b01 (assert) and `out_line`=`intx_sel`, one cycle after the edge that samples the rise. `out_line` values 0 to 3 stand for lines A to D.
- R2: In legacy mode, a fall of the OR of all sources while the line is up gives one descriptor with `out_kind`=2'b10 (deassert). Its `out_line` is the line used by the matching assert, one cycle after the edge that samples the fall.
- R3: While `msi_en` or `tbl_en` is 1, no assert message is produced, whatever the source levels do.
- R4: If a message mode is enabled while the legacy line is up, a deassert message for the asserted line is sent on the next cycle, ahead of any memory write.
- R5: In single-address mode (`msi_en`=1, `tbl_en`=0), a write (`out_kind`=2'b11) has `out_addr`=`msi_addr`. Its `out_data` is `msi_data` with the low k bits replaced by the vector number modulo 2^k, where k is `msi_grant_log2`, clamped to log2(NUM_VEC).
- R6: In table mode (`tbl_en`=1), a write for vector v carries the address and data held in table entry v. Table mode takes precedence over `msi_en`.
- R7: In table mode, a firing of a vector whose mask bit is set is held pending with no output. The write is sent the cycle after the edge that clears the mask through the table write port.
- R8: When several vectors are pending, one write goes out per cycle, lowest vector number first.
- R9: In a message mode, each rising edge of a source gives exactly one memory write. The first such write is valid two cycles after the edge that samples the rise.
- R10: While reset is asserted, and on the first cycle after it, `out_valid` is 0 and the legacy line is down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_level | input | NUM_VEC | Interrupt request level per source/vector |
| intx_sel | input | 2 | Legacy line used for the next assert (0=A to 3=D) |
| msi_en | input | 1 | Enable single-address message writes |
| tbl_en | input | 1 | Enable table-driven message writes |
| msi_addr | input | ADDR_W | Shared write address for single-address mode |
| msi_data | input | DATA_W | Base data value for single-address mode |
| msi_grant_log2 | input | K_W | log2 of the number of granted vectors |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | VEC_W | Table entry to write |
| tbl_wr_addr | input | ADDR_W | Address written into the entry |
| tbl_wr_data | input | DATA_W | Data written into the entry |
| tbl_wr_mask | input | 1 | Mask bit written into the entry |
| out_valid | output | 1 | Descriptor valid this cycle |
| out_kind | output | 2 | 00 idle, 01 assert, 10 deassert, 11 memory write |
| out_line | output | 2 | Legacy line for assert/deassert |
| out_addr | output | ADDR_W | Write address |
| out_data | output | DATA_W | Write data |

## Verification
Legacy messages are due one cycle after the clock edge that samples the level change. Memory writes are due two cycles after it, because the edge is first caught in a pending bit. An unmasked held vector is due one cycle after the edge that clears its mask. The bench changes inputs on falling edges and samples on later falling edges. For each stimulus it counts exactly one or two edges before it checks. On the cycles in between, it checks that the output is idle, so a descriptor that comes early, late or twice is caught. Several vectors fired together are checked on consecutive cycles in ascending vector order.

// File: rtl/irq_mode_pkg.sv
package irq_mode_pkg;
   typedef enum logic [1:0] {
      DESC_IDLE     = 2'b00,
      DESC_ASSERT   = 2'b01,
      DESC_DEASSERT = 2'b10,
      DESC_WRITE    = 2'b11
   } desc_kind_e;
endpackage

// File: rtl/irq_edge_pend.sv
// Rising-edge capture into per-vector pending bits.
module irq_edge_pend #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src,
   input  logic         clr_all,
   input  logic [N-1:0] take,
   output logic [N-1:0] pend
);
   logic [N-1:0] src_q;
   logic [N-1:0] rise;

   assign rise = src & ~src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         pend  <= '0;
      end else begin
         src_q <= src;
         if (clr_all) pend <= '0;
         else         pend <= (pend & ~take) | rise;
      end
   end
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority pick, lowest index wins.
module irq_prio_pick #(
   parameter int N = 4,
   parameter int W = 2
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic [W-1:0] idx,
   output logic         any
);
   always_comb begin
      gnt = '0;
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt = '0;
            gnt[i] = 1'b1;
            idx = W'(i);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_legacy_line.sv
// Tracks the virtual legacy line and requests assert/deassert messages.
module irq_legacy_line (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       level,
   input  logic       msg_mode,
   input  logic [1:0] line_sel,
   output logic       ev,
   output logic       ev_deassert,
   output logic [1:0] ev_line
);
   logic       up_q;
   logic [1:0] line_q;
   logic       want_up;

   assign want_up     = level && !msg_mode;
   assign ev          = (want_up != up_q);
   assign ev_deassert = up_q;
   assign ev_line     = up_q ? line_q : line_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q   <= 1'b0;
         line_q <= 2'd0;
      end else if (ev) begin
         up_q <= want_up;
         if (!up_q) line_q <= line_sel;
      end
   end
endmodule

// File: rtl/irq_mode_ctrl.sv
module irq_mode_ctrl
   import irq_mode_pkg::*;
#(
   parameter int NUM_VEC = 4,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16,
   localparam int VEC_W  = $clog2(NUM_VEC),
   localparam int K_W    = $clog2(VEC_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_VEC-1:0] src_level,
   input  logic [1:0]        intx_sel,
   input  logic              msi_en,
   input  logic              tbl_en,
   input  logic [ADDR_W-1:0] msi_addr,
   input  logic [DATA_W-1:0] msi_data,
   input  logic [K_W-1:0]    msi_grant_log2,
   input  logic              tbl_we,
   input  logic [VEC_W-1:0]  tbl_idx,
   input  logic [ADDR_W-1:0] tbl_wr_addr,
   input  logic [DATA_W-1:0] tbl_wr_data,
   input  logic              tbl_wr_mask,
   output logic              out_valid,
   output logic [1:0]        out_kind,
   output logic [1:0]        out_line,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_data
);
   generate
      if (NUM_VEC < 2 || (NUM_VEC & (NUM_VEC - 1)) != 0) begin : g_bad_vec
         $error("NUM_VEC must be a power of two of at least 2");
      end
      if (DATA_W < VEC_W || ADDR_W < 1) begin : g_bad_width
         $error("DATA_W must hold a vector number");
      end
   endgenerate

   logic                msg_mode;
   logic [NUM_VEC-1:0]  pend, take, req, gnt, mask_q;
   logic [VEC_W-1:0]    idx;
   logic                any, fire;
   logic                leg_ev, leg_deassert;
   logic [1:0]          leg_line;
   logic [ADDR_W-1:0]   tbl_addr_q [NUM_VEC];
   logic [DATA_W-1:0]   tbl_data_q [NUM_VEC];
   logic [K_W-1:0]      k_eff;
   logic [DATA_W-1:0]   fold_mask, single_data, wr_data;
   logic [ADDR_W-1:0]   wr_addr;

   assign msg_mode = msi_en || tbl_en;

   irq_legacy_line u_legacy (
      .clk(clk), .rst_n(rst_n), .level(|src_level), .msg_mode(msg_mode),
      .line_sel(intx_sel), .ev(leg_ev), .ev_deassert(leg_deassert),
      .ev_line(leg_line)
   );

   irq_edge_pend #(.N(NUM_VEC)) u_pend (
      .clk(clk), .rst_n(rst_n), .src(src_level), .clr_all(!msg_mode),
      .take(take), .pend(pend)
   );

   // Vector table with per-entry mask
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         for (int i = 0; i < NUM_VEC; i++) begin
            tbl_addr_q[i] <= '0;
            tbl_data_q[i] <= '0;
         end
      end else if (tbl_we) begin
         tbl_addr_q[tbl_idx] <= tbl_wr_addr;
         tbl_data_q[tbl_idx] <= tbl_wr_data;
         mask_q[tbl_idx]     <= tbl_wr_mask;
      end
   end

   assign req = tbl_en ? (pend & ~mask_q) : pend;

   irq_prio_pick #(.N(NUM_VEC), .W(VEC_W)) u_pick (
      .req(req), .gnt(gnt), .idx(idx), .any(any)
   );

   // Legacy deassert takes the slot ahead of any write
   assign fire = any && msg_mode && !leg_ev;
   assign take = fire ? gnt : '0;

   // Vector folding for the single-address form
   assign k_eff       = (msi_grant_log2 > K_W'(VEC_W)) ? K_W'(VEC_W) : msi_grant_log2;
   assign fold_mask   = ~({DATA_W{1'b1}} << k_eff);
   assign single_data = (msi_data & ~fold_mask) | (DATA_W'(idx) & fold_mask);
   assign wr_addr     = tbl_en ? tbl_addr_q[idx] : msi_addr;
   assign wr_data     = tbl_en ? tbl_data_q[idx] : single_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_kind  <= DESC_IDLE;
         out_line  <= 2'd0;
         out_addr  <= '0;
         out_data  <= '0;
      end else if (leg_ev) begin
         out_valid <= 1'b1;
         out_kind  <= leg_deassert ? DESC_DEASSERT : DESC_ASSERT;
         out_line  <= leg_line;
         out_addr  <= '0;
         out_data  <= '0;
      end else if (fire) begin
         out_valid <= 1'b1;
         out_kind  <= DESC_WRITE;
         out_line  <= 2'd0;
         out_addr  <= wr_addr;
         out_data  <= wr_data;
      end else begin
         out_valid <= 1'b0;
         out_kind  <= DESC_IDLE;
         out_line  <= 2'd0;
         out_addr  <= '0;
         out_data  <= '0;
      end
   end
endmodule

// File: rtl/irq_mode_ctrl_chk.sv
module irq_mode_ctrl_chk
   import irq_mode_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              msi_en,
   input logic              tbl_en,
   input logic [ADDR_W-1:0] msi_addr,
   input logic              out_valid,
   input logic [1:0]        out_kind,
   input logic [ADDR_W-1:0] out_addr
);
   logic up_q, eff_up, is_as, is_de, is_wr;

   assign is_as  = out_valid && out_kind == DESC_ASSERT;
   assign is_de  = out_valid && out_kind == DESC_DEASSERT;
   assign is_wr  = out_valid && out_kind == DESC_WRITE;
   assign eff_up = is_as ? 1'b1 : (is_de ? 1'b0 : up_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) up_q <= 1'b0;
      else        up_q <= eff_up;
   end

   assert_reset_idle_R10: assert property (@(posedge clk) !rst_n |=> !out_valid);
   assert_assert_when_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
      is_as |-> !up_q);
   assert_deassert_when_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      is_de |-> up_q);
   assert_no_legacy_in_msg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      is_as |-> $past(!msi_en && !tbl_en));
   assert_deassert_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_up && (msi_en || tbl_en)) |=> is_de);
   assert_single_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && $past(msi_en && !tbl_en)) |-> out_addr == $past(msi_addr));
   assert_write_in_msg_R9: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr |-> $past(msi_en || tbl_en));
endmodule

bind irq_mode_ctrl irq_mode_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .tbl_en(tbl_en),
   .msi_addr(msi_addr), .out_valid(out_valid), .out_kind(out_kind),
   .out_addr(out_addr)
);

// File: tb/irq_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_mode_ctrl_tb_top;
   localparam int NV = 4;
   localparam int AW = 16;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NV-1:0] src_level = '0;
   logic [1:0]    intx_sel = 2'd0;
   logic          msi_en = 1'b0, tbl_en = 1'b0;
   logic [AW-1:0] msi_addr = 16'hFEE0;
   logic [DW-1:0] msi_data = 16'hBEE7;
   logic [1:0]    msi_grant_log2 = 2'd0;
   logic          tbl_we = 1'b0;
   logic [1:0]    tbl_idx = 2'd0;
   logic [AW-1:0] tbl_wr_addr = '0;
   logic [DW-1:0] tbl_wr_data = '0;
   logic          tbl_wr_mask = 1'b0;
   logic          out_valid;
   logic [1:0]    out_kind, out_line;
   logic [AW-1:0] out_addr;
   logic [DW-1:0] out_data;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   irq_mode_ctrl #(.NUM_VEC(NV), .ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_level(src_level), .intx_sel(intx_sel),
      .msi_en(msi_en), .tbl_en(tbl_en), .msi_addr(msi_addr), .msi_data(msi_data),
      .msi_grant_log2(msi_grant_log2), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
      .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data), .tbl_wr_mask(tbl_wr_mask),
      .out_valid(out_valid), .out_kind(out_kind), .out_line(out_line),
      .out_addr(out_addr), .out_data(out_data)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk_idle(string tag);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL %s: out_valid=%0b expected 0 (kind=%0d)", tag, out_valid, out_kind);
      end
   endtask

   task automatic chk_msg(logic [1:0] kind, logic [1:0] line, string tag);
      checks++;
      if (out_valid !== 1'b1 || out_kind !== kind || out_line !== line) begin
         errors++;
         $display("FAIL %s: valid=%0b kind=%0d line=%0d expected valid=1 kind=%0d line=%0d",
                  tag, out_valid, out_kind, out_line, kind, line);
      end
   endtask

   task automatic chk_wr(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
      checks++;
      if (out_valid !== 1'b1 || out_kind !== 2'b11 || out_addr !== a || out_data !== d) begin
         errors++;
         $display("FAIL %s: valid=%0b kind=%0d addr=%h data=%h expected write addr=%h data=%h",
                  tag, out_valid, out_kind, out_addr, out_data, a, d);
      end
   endtask

   task automatic tbl_write(int v, logic [AW-1:0] a, logic [DW-1:0] d, logic m);
      tbl_we = 1'b1; tbl_idx = 2'(v); tbl_wr_addr = a; tbl_wr_data = d; tbl_wr_mask = m;
      step();
      tbl_we = 1'b0;
   endtask

   function automatic logic [AW-1:0] t_addr(int v);
      return 16'h1000 + 16'(v * 16'h40);
   endfunction
   function automatic logic [DW-1:0] t_data(int v);
      return 16'h7700 + 16'(v * 3);
   endfunction
   function automatic logic [DW-1:0] fold(logic [DW-1:0] base, int k, int v);
      int m;
      m = (1 << k) - 1;
      return (base & ~16'(m)) | 16'(v & m);
   endfunction

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      report();
      $finish;
   end

   initial begin
      step();
      chk_idle("R10 during reset");
      step();
      rst_n = 1'b1;
      step();
      chk_idle("R10 after reset");

      // R1/R2: every legacy line against every source
      for (int l = 0; l < 4; l++) begin
         for (int s = 0; s < NV; s++) begin
            intx_sel = 2'(l);
            src_level = NV'(1 << s);
            step(); chk_msg(2'b01, 2'(l), "R1 legacy assert");
            step(); chk_idle("R1 single assert");
            src_level = '0;
            intx_sel = 2'(3 - l);
            step(); chk_msg(2'b10, 2'(l), "R2 legacy deassert");
            step(); chk_idle("R2 single deassert");
         end
      end

      // R5/R9/R3: single-address mode, every grant size and vector
      msi_en = 1'b1;
      for (int k = 0; k <= 2; k++) begin
         msi_grant_log2 = 2'(k);
         for (int v = 0; v < NV; v++) begin
            src_level = NV'(1 << v);
            step(); chk_idle("R9 write not yet due, R3 no assert");
            step(); chk_wr(msi_addr, fold(msi_data, k, v), "R5 folded single write");
            src_level = '0;
            step(); chk_idle("R9 one write per edge");
         end
      end
      // grant above the vector count clamps to log2(NUM_VEC)
      msi_grant_log2 = 2'd3;
      src_level = 4'b1000;
      step(); step(); chk_wr(msi_addr, fold(msi_data, 2, 3), "R5 clamped grant");
      src_level = '0; step();

      // R8: all vectors at once, lowest first
      msi_grant_log2 = 2'd2;
      src_level = 4'hF;
      step(); chk_idle("R8 pending stage");
      for (int v = 0; v < NV; v++) begin
         step(); chk_wr(msi_addr, fold(msi_data, 2, v), "R8 priority order");
      end
      step(); chk_idle("R8 drained");
      src_level = '0; step();

      // R6: table mode (msi_en still set, table wins)
      for (int v = 0; v < NV; v++) tbl_write(v, t_addr(v), t_data(v), 1'b0);
      chk_idle("R6 table writes silent");
      tbl_en = 1'b1;
      for (int v = 0; v < NV; v++) begin
         src_level = NV'(1 << v);
         step(); step(); chk_wr(t_addr(v), t_data(v), "R6 table entry write");
         src_level = '0;
         step(); chk_idle("R6 single write");
      end

      // R7: masked vector held until unmask
      tbl_write(2, t_addr(2), t_data(2), 1'b1);
      src_level = 4'b0100;
      for (int i = 0; i < 4; i++) begin
         step(); chk_idle("R7 masked vector held");
      end
      src_level = 4'b0110;
      step(); chk_idle("R7 other vector pending");
      step(); chk_wr(t_addr(1), t_data(1), "R7 unmasked neighbour passes");
      tbl_we = 1'b1; tbl_idx = 2'd2; tbl_wr_addr = t_addr(2);
      tbl_wr_data = t_data(2); tbl_wr_mask = 1'b0;
      step(); tbl_we = 1'b0;
      chk_idle("R7 mask clearing edge");
      step(); chk_wr(t_addr(2), t_data(2), "R7 write after unmask");
      step(); chk_idle("R7 single release");
      src_level = '0; step();

      // R4: message mode enabled with the legacy line up
      tbl_en = 1'b0; msi_en = 1'b0;
      intx_sel = 2'd2;
      src_level = 4'b0001;
      step(); chk_msg(2'b01, 2'd2, "R4 setup assert");
      step(); chk_idle("R4 setup quiet");
      msi_en = 1'b1; intx_sel = 2'd0;
      step(); chk_msg(2'b10, 2'd2, "R4 deassert first");
      step(); chk_idle("R4 no write without new edge");
      src_level = '0;
      step(); chk_idle("R3 fall in message mode silent");
      src_level = 4'b0001;
      step(); chk_idle("R3 rise in message mode no assert");
      step(); chk_wr(msi_addr, fold(msi_data, 2, 0), "R9 write after legacy handoff");
      src_level = '0; step();

      report();
      $finish;
   end
endmodule